// File: doc/BRIEF.md
# Type-3 Command Ring Parser

This block reads 32-bit command words from a circular ring in memory and runs the type-3 packets it finds there. The ring starts at a byte base address and holds a power-of-two number of dwords. The block keeps an absolute read pointer that counts dwords. A word is fetched from `base + 4 * (rptr mod ring_dwords)`. Software (here, the bench) stores packets, raises the write pointer and pulses `kick`. The block then keeps parsing while the read pointer is below the write pointer.

Six packets are handled:
- a burst write into a shader register file;
- a memory or literal poll;
- an end-of-pipe write of a value or a timestamp to memory;
- an acquire, which is skipped;
- an event write, which is consumed;
- a dispatch, which emits a one-cycle pulse with three group counts.

A poll that fails moves the read pointer back to the start of its own packet and pauses until the next `kick`, so the whole packet runs again later. A header the block cannot accept stops it with a sticky error until reset. Indirect chaining is one such header.

Memory traffic uses a single request/acknowledge port. A read returns 32 bits and a write stores 64 bits.

Top module: `cmd_ring_parser`

## Requirements
- R1: After reset the read pointer is 0, `busy`, `err`, `wait_hold`, `mem_req`, `reg_we` and `disp_pulse` are low, and nothing is fetched until `kick`.
- R2: Ring fetches read byte address `ring_base + 4*(rptr mod 2^RING_LOG2)`, and the read pointer advances by one per dword. A kick with `rptr == wptr` fetches nothing and leaves the block idle. Parsing continues while `rptr < wptr` and wraps around the ring.
- R3: A header is laid out as type [31:30], count n [29:16] and opcode [15:8]. A type other than 3 sets `err` and halts. `err` is sticky, and a halted block makes no requests and ignores later kicks until reset.
- R4: Opcode 0x76 takes a start index and then n dwords. Each dword is written on the register port, at consecutive indices starting from the start index.
- R5: Opcode 0x3C with n=5 is a poll with body info, address low, address high, reference, mask and timeout. Info bits [2:0] select the compare, where 3 is equal and 5 is unsigned greater-or-equal. Info bit 4 set means the 32-bit word read at the 64-bit address is compared with the reference. A passing poll lets parsing continue.
- R6: When a poll compare fails, the read pointer moves back by 7 so that it points to the poll header. `wait_hold` is raised and the block goes idle. The next kick runs the poll again.
- R7: A poll with info bit 4 clear compares the reference against itself, so it always passes and makes no memory read.
- R8: Opcode 0x49 with n=6 is an end-of-pipe write with body event [7:0], selects (data select in bits [31:29]), address low, address high, value low, value high and a trailing dword. A data select of 1 or 2 writes the 64-bit value to the address.
- R9: An end-of-pipe write with data select 3 and event 0x14 writes a free-running 64-bit cycle counter that starts at 0 on reset.
- R10: Opcode 0x58 with n=6 (7 body dwords) and opcode 0x46 with n=0 (1 body dword) are consumed with no memory write, no register write and no pulse.
- R11: Opcode 0x15 with n=3 carries X, Y and Z group counts and a flags dword. It raises `disp_pulse` for exactly one cycle, with the three counts on `disp_x`, `disp_y` and `disp_z`.
- R12: The following halt with `err`, and the packet's body is not run:
  - an unknown opcode;
  - the indirect-chain opcode 0x3F;
  - a count other than the fixed one for opcodes 0x3C, 0x49, 0x58, 0x46 and 0x15.
- R13: A poll compare code other than 3 or 5 halts with `err`. So does an end-of-pipe data select outside 1 to 3, or a data select of 3 with an event other than 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start or resume parsing |
| ring_base | input | AW | Byte address of ring dword 0 |
| wptr | input | PTR_W | Absolute write pointer in dwords |
| rptr | output | PTR_W | Absolute read pointer in dwords |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = 64-bit write, 0 = 32-bit read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| reg_we | output | 1 | Register-file write strobe |
| reg_idx | output | RIDX_W | Register index |
| reg_wdata | output | 32 | Register data |
| disp_pulse | output | 1 | One-cycle dispatch trigger |
| disp_x | output | 32 | Group count X |
| disp_y | output | 32 | Group count Y |
| disp_z | output | 32 | Group count Z |
| busy | output | 1 | Parsing in progress |
| wait_hold | output | 1 | Paused on a failed poll |
| err | output | 1 | Sticky halt on a bad packet |

## Verification
The properties assume three things about the memory side:
- `mem_ack` comes only while a request is held, and lasts one cycle;
- `mem_rdata` is valid in that cycle;
- the ring words between the read and write pointers stay unchanged while the block is busy.

They also assume that `wptr` never decreases. The bench meets these rules as follows:
- its memory model answers each request once, one cycle later;
- it writes ring words and test cells only while `busy` is low;
- it raises the write pointer only before a kick;
- it keeps every scenario shorter than the 16-dword ring it uses, so a rewound poll still finds its words.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
   localparam logic [7:0] OP_REGBURST = 8'h76;
   localparam logic [7:0] OP_ACQUIRE  = 8'h58;
   localparam logic [7:0] OP_EOPWRITE = 8'h49;
   localparam logic [7:0] OP_POLL     = 8'h3C;
   localparam logic [7:0] OP_DISPATCH = 8'h15;
   localparam logic [7:0] OP_CHAIN    = 8'h3F;
   localparam logic [7:0] OP_EVENT    = 8'h46;
   localparam logic [7:0] EV_FLUSH_TS = 8'h14;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CHK, ST_RD, ST_DEC, ST_EXEC, ST_MRD, ST_MWR, ST_HALT
   } cmdp_state_t;

   // Opcode known and count equal to its fixed length (burst: any count)
   function automatic logic hdr_len_ok(input logic [7:0] op, input logic [13:0] n);
      case (op)
         OP_REGBURST: hdr_len_ok = 1'b1;
         OP_POLL:     hdr_len_ok = (n == 14'd5);
         OP_EOPWRITE: hdr_len_ok = (n == 14'd6);
         OP_ACQUIRE:  hdr_len_ok = (n == 14'd6);
         OP_DISPATCH: hdr_len_ok = (n == 14'd3);
         OP_EVENT:    hdr_len_ok = (n == 14'd0);
         default:     hdr_len_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/cmdp_ring_addr.sv
module cmdp_ring_addr #(
   parameter int AW           = 48,
   parameter int RING_LOG2    = 10,
   parameter int PTR_W        = 32,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic [AW-1:0]    base,
   input  logic [PTR_W-1:0] ptr,
   output logic [AW-1:0]    addr
);
   localparam int OFS_W = RING_LOG2 + 2;

   if (OFS_W > AW) begin : g_bad_aw
      $error("ring larger than address space");
   end
   if (RING_LOG2 > PTR_W) begin : g_bad_ptr
      $error("pointer narrower than ring index");
   end

   logic [OFS_W-1:0] ofs;
   assign ofs = {ptr[RING_LOG2-1:0], 2'b00};

   if (BASE_ALIGNED) begin : g_or
      if (OFS_W == AW) begin : g_full
         assign addr = ofs;
      end else begin : g_part
         assign addr = {base[AW-1:OFS_W], ofs};
      end
   end else begin : g_add
      assign addr = base + AW'(ofs);
   end
endmodule

// File: rtl/cmdp_stamp.sv
module cmdp_stamp #(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts
);
   if (TS_W < 8 || TS_W > 64) begin : g_bad_w
      $error("timestamp width must be 8..64");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ts <= '0;
      else        ts <= ts + TS_W'(1);
   end
endmodule

// File: rtl/cmdp_cmp.sv
module cmdp_cmp (
   input  logic [2:0]  fn,
   input  logic [31:0] lhs,
   input  logic [31:0] rhs,
   output logic        fn_ok,
   output logic        pass
);
   localparam logic [2:0] FN_EQ  = 3'd3;
   localparam logic [2:0] FN_GEQ = 3'd5;

   always_comb begin
      fn_ok = 1'b1;
      pass  = 1'b0;
      case (fn)
         FN_EQ:   pass = (lhs == rhs);
         FN_GEQ:  pass = (lhs >= rhs);
         default: fn_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmd_ring_parser.sv
module cmd_ring_parser
   import cmdp_pkg::*;
#(
   parameter int AW           = 48,
   parameter int RING_LOG2    = 10,
   parameter int PTR_W        = 32,
   parameter int RIDX_W       = 16,
   parameter int TS_W         = 64,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic [AW-1:0]     ring_base,
   input  logic [PTR_W-1:0]  wptr,
   output logic [PTR_W-1:0]  rptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              reg_we,
   output logic [RIDX_W-1:0] reg_idx,
   output logic [31:0]       reg_wdata,
   output logic              disp_pulse,
   output logic [31:0]       disp_x,
   output logic [31:0]       disp_y,
   output logic [31:0]       disp_z,
   output logic              busy,
   output logic              wait_hold,
   output logic              err
);
   localparam int BODY_N = 8;
   localparam logic [PTR_W-1:0] POLL_LEN = PTR_W'(7);

   if (RIDX_W < 1 || RIDX_W > 32) begin : g_bad_ridx
      $error("register index width must be 1..32");
   end
   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("address width must be 8..64");
   end

   cmdp_state_t     st;
   logic [31:0]     word;
   logic            at_hdr;
   logic [7:0]      op;
   logic [13:0]     cnt;
   logic [13:0]     bidx;
   logic [31:0]     body [BODY_N];
   logic [RIDX_W-1:0] ridx;
   logic [63:0]     wval;
   logic [AW-1:0]   ring_addr;
   logic [TS_W-1:0] ts;
   logic            fn_ok, pass;
   logic [31:0]     cmp_lhs;
   logic [63:0]     poll_addr, eop_addr;
   logic [2:0]      dsel;

   cmdp_ring_addr #(.AW(AW), .RING_LOG2(RING_LOG2), .PTR_W(PTR_W),
                    .BASE_ALIGNED(BASE_ALIGNED)) u_addr (
      .base(ring_base), .ptr(rptr), .addr(ring_addr));

   cmdp_stamp #(.TS_W(TS_W)) u_stamp (.clk(clk), .rst_n(rst_n), .ts(ts));

   assign cmp_lhs = (st == ST_MRD) ? mem_rdata : body[3];

   cmdp_cmp u_cmp (.fn(body[0][2:0]), .lhs(cmp_lhs), .rhs(body[3]),
                   .fn_ok(fn_ok), .pass(pass));

   assign poll_addr = {body[2], body[1]};
   assign eop_addr  = {body[3], body[2]};
   assign dsel      = body[1][31:29];

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ring_addr;
      case (st)
         ST_RD:  mem_req = 1'b1;
         ST_MRD: begin mem_req = 1'b1; mem_addr = poll_addr[AW-1:0]; end
         ST_MWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = eop_addr[AW-1:0]; end
         default: ;
      endcase
   end

   assign mem_wdata = wval;
   assign busy      = (st != ST_IDLE) && (st != ST_HALT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; rptr <= '0; word <= '0; at_hdr <= 1'b0;
         op <= '0; cnt <= '0; bidx <= '0; ridx <= '0; wval <= '0;
         reg_we <= 1'b0; reg_idx <= '0; reg_wdata <= '0;
         disp_pulse <= 1'b0; disp_x <= '0; disp_y <= '0; disp_z <= '0;
         wait_hold <= 1'b0; err <= 1'b0;
         for (int i = 0; i < BODY_N; i++) body[i] <= '0;
      end else begin
         reg_we     <= 1'b0;
         disp_pulse <= 1'b0;
         case (st)
            ST_IDLE: if (kick) begin
               wait_hold <= 1'b0;
               st        <= ST_CHK;
            end
            ST_CHK: begin
               at_hdr <= 1'b1;
               st     <= (rptr < wptr) ? ST_RD : ST_IDLE;
            end
            ST_RD: if (mem_ack) begin
               word <= mem_rdata;
               rptr <= rptr + PTR_W'(1);
               st   <= ST_DEC;
            end
            ST_DEC: begin
               if (at_hdr) begin
                  if (word[31:30] != 2'b11 || !hdr_len_ok(word[15:8], word[29:16])) begin
                     err <= 1'b1;
                     st  <= ST_HALT;
                  end else begin
                     op     <= word[15:8];
                     cnt    <= word[29:16];
                     bidx   <= '0;
                     at_hdr <= 1'b0;
                     st     <= ST_RD;
                  end
               end else begin
                  if (op == OP_REGBURST) begin
                     if (bidx == '0) begin
                        ridx <= word[RIDX_W-1:0];
                     end else begin
                        reg_we    <= 1'b1;
                        reg_idx   <= ridx;
                        reg_wdata <= word;
                        ridx      <= ridx + RIDX_W'(1);
                     end
                  end else begin
                     body[bidx[2:0]] <= word;
                  end
                  bidx <= bidx + 14'd1;
                  if (bidx == cnt) st <= (op == OP_REGBURST) ? ST_CHK : ST_EXEC;
                  else             st <= ST_RD;
               end
            end
            ST_EXEC: begin
               st <= ST_CHK;
               case (op)
                  OP_POLL: begin
                     if (!fn_ok) begin
                        err <= 1'b1; st <= ST_HALT;
                     end else if (body[0][4]) begin
                        st <= ST_MRD;
                     end
                  end
                  OP_EOPWRITE: begin
                     if (dsel == 3'd1 || dsel == 3'd2) begin
                        wval <= {body[5], body[4]};
                        st   <= ST_MWR;
                     end else if (dsel == 3'd3 && body[0][7:0] == EV_FLUSH_TS) begin
                        wval <= 64'(ts);
                        st   <= ST_MWR;
                     end else begin
                        err <= 1'b1; st <= ST_HALT;
                     end
                  end
                  OP_DISPATCH: begin
                     disp_pulse <= 1'b1;
                     disp_x <= body[0]; disp_y <= body[1]; disp_z <= body[2];
                  end
                  default: ;
               endcase
            end
            ST_MRD: if (mem_ack) begin
               if (pass) begin
                  st <= ST_CHK;
               end else begin
                  rptr      <= rptr - POLL_LEN;
                  wait_hold <= 1'b1;
                  st        <= ST_IDLE;
               end
            end
            ST_MWR: if (mem_ack) st <= ST_CHK;
            default: st <= ST_HALT;
         endcase
      end
   end
endmodule

// File: rtl/cmd_ring_parser_chk.sv
module cmd_ring_parser_chk #(
   parameter int AW    = 48,
   parameter int PTR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [AW-1:0]    mem_addr,
   input logic [PTR_W-1:0] rptr,
   input logic             busy,
   input logic             err,
   input logic             wait_hold,
   input logic             reg_we,
   input logic             disp_pulse
);
   // R1: an idle or halted block issues no memory traffic
   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R2: a request holds its address and direction until acknowledged
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R3: error is sticky
   a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R3: halted block makes no requests and is not busy
   a_r3_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_req && !busy));

   // R6: the read pointer only ever moves back by one poll length, with hold raised
   a_r6_rewind_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rptr < $past(rptr)) |-> ((rptr == $past(rptr) - PTR_W'(7)) && wait_hold));

   // R11: dispatch pulse lasts one cycle
   a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      disp_pulse |=> !disp_pulse);

   // R4: register writes never coincide with a memory write
   a_r4_reg_not_mem: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !(mem_req && mem_we));
endmodule

bind cmd_ring_parser cmd_ring_parser_chk #(.AW(AW), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ack(mem_ack), .mem_addr(mem_addr), .rptr(rptr), .busy(busy),
   .err(err), .wait_hold(wait_hold), .reg_we(reg_we), .disp_pulse(disp_pulse));

// File: tb/cmd_ring_parser_test.sv
`timescale 1ns/1ps
module cmd_ring_parser_test;
   localparam int AW = 16;
   localparam int RL = 4;
   localparam int RING_DW = 1 << RL;
   localparam int RING_IDX = 16;   // ring base dword index (byte 0x40)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0;
   logic [31:0] wptr = '0;
   logic [31:0] rptr;
   logic        mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        reg_we;
   logic [15:0] reg_idx;
   logic [31:0] reg_wdata;
   logic        disp_pulse;
   logic [31:0] disp_x, disp_y, disp_z;
   logic        busy, wait_hold, err;

   always #2 clk = ~clk;

   cmd_ring_parser #(.AW(AW), .RING_LOG2(RL), .PTR_W(32), .RIDX_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(16'h0040), .wptr(wptr),
      .rptr(rptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .disp_pulse(disp_pulse), .disp_x(disp_x), .disp_y(disp_y), .disp_z(disp_z),
      .busy(busy), .wait_hold(wait_hold), .err(err));

   // memory model with a poke port for the tasks
   logic [31:0] mem [256];
   logic        poke_en = 1'b0;
   logic [7:0]  poke_idx = '0;
   logic [31:0] poke_val = '0;
   int          nwr;
   longint      cyc;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mem_rdata <= '0; nwr <= 0; cyc <= 0;
      end else begin
         cyc <= cyc + 1;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[9:2]]      <= mem_wdata[31:0];
               mem[mem_addr[9:2] + 1]  <= mem_wdata[63:32];
               nwr <= nwr + 1;
            end else begin
               mem_rdata <= mem[mem_addr[9:2]];
            end
         end else begin
            mem_ack <= 1'b0;
         end
      end
      if (poke_en) mem[poke_idx] <= poke_val;
   end

   // output monitors, sampled away from the active edge
   int          nreg = 0, ndisp = 0;
   logic [15:0] log_idx [64];
   logic [31:0] log_dat [64];
   logic [31:0] dx, dy, dz;
   always @(negedge clk) begin
      if (reg_we) begin
         log_idx[nreg % 64] = reg_idx;
         log_dat[nreg % 64] = reg_wdata;
         nreg = nreg + 1;
      end
      if (disp_pulse) begin
         dx = disp_x; dy = disp_y; dz = disp_z;
         ndisp = ndisp + 1;
      end
   end

   int total = 0, bad = 0;
   int wr = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input int idx, input logic [31:0] v);
      @(negedge clk);
      poke_en = 1'b1; poke_idx = 8'(idx); poke_val = v;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic push(input logic [31:0] w);
      poke(RING_IDX + (wr % RING_DW), w);
      wr++;
   endtask

   function automatic logic [31:0] hdr(input logic [1:0] t, input logic [7:0] op, input int n);
      return {t, 14'(n), op, 8'h00};
   endfunction

   task automatic run();
      @(negedge clk);
      wptr = 32'(wr);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      @(negedge clk);
      for (int g = 0; g < 400 && busy; g++) @(negedge clk);
      if (busy) check("watchdog busy", 1, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr = 0; wptr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 rptr", rptr, 0);
      check("R1 busy", busy, 0);
      check("R1 err", err, 0);
      check("R1 hold", wait_hold, 0);
      check("R1 req", mem_req, 0);
      check("R1 reg_we/disp", {reg_we, disp_pulse}, 0);
      run();   // R2: empty ring
      check("R2 empty kick rptr", rptr, 0);
      check("R2 empty kick busy", busy, 0);
   endtask

   task automatic t_burst();
      int r0 = nreg;
      push(hdr(2'b11, 8'h76, 3)); push(32'h0000_0020);
      push(32'hAAAA_0001); push(32'hBBBB_0002); push(32'hCCCC_0003);
      run();
      check("R4 count", nreg - r0, 3);
      for (int i = 0; i < 3; i++) begin
         check("R4 idx", log_idx[(r0 + i) % 64], 16'h20 + 16'(i));
      end
      check("R4 data0", log_dat[r0 % 64], 32'hAAAA_0001);
      check("R4 data2", log_dat[(r0 + 2) % 64], 32'hCCCC_0003);
      check("R2 rptr after burst", rptr, 5);
   endtask

   task automatic t_skip();
      int w0 = nwr, r0 = nreg, d0 = ndisp;
      push(hdr(2'b11, 8'h46, 0)); push(32'h0000_0015);
      push(hdr(2'b11, 8'h58, 6));
      for (int i = 0; i < 7; i++) push(32'hFFFF_0000 + 32'(i));
      run();
      check("R10 no mem write", nwr - w0, 0);
      check("R10 no reg write", nreg - r0, 0);
      check("R10 no pulse", ndisp - d0, 0);
      check("R10 rptr", rptr, 32'(wr));
   endtask

   task automatic t_dispatch();
      int d0 = ndisp;
      push(hdr(2'b11, 8'h15, 3));
      push(32'd7); push(32'd8); push(32'd9); push(32'h0);
      run();
      check("R11 one pulse", ndisp - d0, 1);
      check("R11 xyz", {dx, dy, dz}, {32'd7, 32'd8, 32'd9});
      check("R2 wrapped rptr", rptr, 32'(wr));
   endtask

   task automatic t_eop_value();
      push(hdr(2'b11, 8'h49, 6));
      push(32'h0000_0005); push(32'h4000_0000);           // data select 2
      push(32'h0000_0200); push(32'h0);
      push(32'h5566_7788); push(32'h1122_3344); push(32'h0);
      run();
      check("R8 low", mem[8'h80], 32'h5566_7788);
      check("R8 high", mem[8'h81], 32'h1122_3344);
   endtask

   task automatic t_eop_stamp();
      logic [63:0] a, b;
      push(hdr(2'b11, 8'h49, 6));
      push(32'h0000_0014); push(32'h6000_0000);           // data select 3
      push(32'h0000_0210); push(32'h0);
      push(32'h0); push(32'h0); push(32'h0);
      run();
      a = {mem[8'h85], mem[8'h84]};
      push(hdr(2'b11, 8'h49, 6));
      push(32'h0000_0014); push(32'h6000_0000);
      push(32'h0000_0218); push(32'h0);
      push(32'h0); push(32'h0); push(32'h0);
      run();
      b = {mem[8'h87], mem[8'h86]};
      check("R9 stamp nonzero", a != 0, 1);
      check("R9 stamp below cycle count", b < 64'(cyc), 1);
      check("R9 stamp grows", b > a, 1);
   endtask

   task automatic t_poll_literal();
      int d0 = ndisp, w0 = nwr;
      push(hdr(2'b11, 8'h3C, 5));
      push(32'h0000_0003); push(32'h0000_0300); push(32'h0);
      push(32'd77); push(32'hFFFF_FFFF); push(32'h0);
      push(hdr(2'b11, 8'h15, 3));
      push(32'd1); push(32'd2); push(32'd3); push(32'h0);
      run();
      check("R7 passes and continues", ndisp - d0, 1);
      check("R7 hold low", wait_hold, 0);
      check("R7 no write", nwr - w0, 0);
   endtask

   task automatic t_poll_mem(input logic [2:0] fn, input logic [31:0] bad_v,
                             input logic [31:0] ref_v, input logic [31:0] good_v);
      int d0 = ndisp;
      int h = wr;
      poke(8'hC0, bad_v);
      push(hdr(2'b11, 8'h3C, 5));
      push({27'd0, 2'b10, 3'b000} | 32'(fn)); push(32'h0000_0300); push(32'h0);
      push(ref_v); push(32'hFFFF_FFFF); push(32'h0);
      push(hdr(2'b11, 8'h15, 3));
      push(32'd4); push(32'd5); push(32'd6); push(32'h0);
      run();
      check("R6 rewound to header", rptr, 32'(h));
      check("R6 hold", wait_hold, 1);
      check("R6 no dispatch", ndisp - d0, 0);
      poke(8'hC0, good_v);
      run();
      check("R5 pass continues", ndisp - d0, 1);
      check("R5 rptr end", rptr, 32'(wr));
      check("R5 hold cleared", wait_hold, 0);
   endtask

   task automatic t_error(input string req, input logic [31:0] h, input int nbody,
                          input logic [31:0] b0, input logic [31:0] b1, input int exp_rptr);
      int d0;
      do_reset();
      push(h);
      for (int i = 0; i < nbody; i++) push(i == 0 ? b0 : (i == 1 ? b1 : 32'h0));
      run();
      check({req, " err"}, err, 1);
      check({req, " halted rptr"}, rptr, 32'(exp_rptr));
      d0 = ndisp;
      push(hdr(2'b11, 8'h15, 3)); push(32'd1); push(32'd1); push(32'd1); push(32'd0);
      run();
      check({req, " R3 ignores kick"}, {err, busy, 32'(ndisp - d0), rptr}, {1'b1, 1'b0, 32'd0, 32'(exp_rptr)});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_reset();
      t_burst();
      t_skip();
      t_dispatch();
      t_eop_value();
      t_eop_stamp();
      t_poll_literal();
      t_poll_mem(3'd5, 32'd2, 32'd5, 32'd9);    // R5 greater-or-equal
      t_poll_mem(3'd3, 32'd6, 32'd7, 32'd7);    // R5 equal
      t_error("R3 type2", hdr(2'b10, 8'h15, 3), 0, 0, 0, 1);
      t_error("R12 unknown op", hdr(2'b11, 8'h99, 0), 0, 0, 0, 1);
      t_error("R12 chain", hdr(2'b11, 8'h3F, 2), 0, 0, 0, 1);
      t_error("R12 bad count", hdr(2'b11, 8'h15, 2), 0, 0, 0, 1);
      t_error("R13 bad compare", hdr(2'b11, 8'h3C, 5), 6, 32'h0000_0010, 32'h300, 7);
      t_error("R13 bad select", hdr(2'b11, 8'h49, 6), 7, 32'h0000_0014, 32'h0, 8);
      t_error("R13 stamp wrong event", hdr(2'b11, 8'h49, 6), 7, 32'h0000_0005, 32'h6000_0000, 8);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule